// File: doc/BRIEF.md
# Serial NOR Flash Identification Probe

This block identifies the serial NOR flash attached to it over an SPI link. Once reset is released it runs one identification exchange on its own, and it runs another whenever a start pulse arrives while it is idle. During the exchange it lowers chip select and sends the identification opcode. It then clocks in three response bytes: a manufacturer code, a memory-type code and a capacity code.

When the manufacturer and memory-type codes match the accepted values and the capacity code is one of the three known codes, the block reports the flash geometry. The geometry consists of the log2 sector size, the sector count, the log2 page size and the page count. It also raises a device-valid flag. In every other case it raises device-unknown and drives the geometry to zero. A done flag marks the end of the exchange, and the result stays in place until the next start pulse.

A small byte shifter inside the block drives the link. The serial clock divider, the clock polarity mode and the accepted manufacturer code are parameters. Higher-level read, erase and program traffic is handled by other logic.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is active, chip select is high, the serial clock rests at its idle level, and done, device-valid and device-unknown are all low. After reset is released the block starts a probe without any start pulse.
- R2: A probe lowers chip select exactly once and keeps it low for 32 serial clock cycles. Over those cycles it sends 0x9F followed by three bytes of 0xA5, most significant bit first. Chip select is high whenever done is high.
- R3: The three bytes received after the opcode are taken, in order, as the manufacturer code, the memory-type code and the capacity code. Each byte is read most significant bit first and sampled on the rising serial clock edge.
- R4: A device is accepted only when the manufacturer code equals the VENDOR_ID parameter (default 0x20) and the memory-type code equals 0x20. Otherwise device-unknown is set, whatever the capacity code is.
- R5: Capacity code 0x11 on an accepted device gives sector shift 15, 4 sectors, page shift 8 and 512 pages.
- R6: Capacity code 0x17 on an accepted device gives sector shift 16, 128 sectors, page shift 8 and 32768 pages.
- R7: Capacity code 0x18 on an accepted device gives sector shift 18, 64 sectors, page shift 8 and 65536 pages.
- R8: Any other outcome sets device-unknown, clears device-valid and drives all four geometry outputs to zero. Exactly one of device-valid and device-unknown is high whenever done is high.
- R9: Done, the status flags and the geometry hold their values until a start pulse arrives while the block is idle. That pulse clears done and both status flags on the next clock edge and begins a new probe.
- R10: A start pulse that arrives while a probe is running is ignored. The running probe completes with a single chip-select assertion, and no second probe follows it.
- R11: With SPI_MODE3 = 0 the serial clock idles low (mode 0). With SPI_MODE3 = 1 it idles high (mode 3). In both modes the outgoing data changes on the falling edge and the incoming data is sampled on the rising edge.
- R12: Each half period of the serial clock lasts CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request for a new probe |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| spi_cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | Probe finished; result is valid |
| dev_ok_o | output | 1 | Device recognised |
| dev_unknown_o | output | 1 | Device not recognised |
| sect_shift_o | output | 5 | log2 of the sector size in bytes |
| sect_count_o | output | 16 | Number of sectors |
| page_shift_o | output | 4 | log2 of the page size in bytes |
| page_count_o | output | 17 | Number of pages |

## Verification
The bench builds two copies of the block. The first uses the defaults: mode 0, CLK_DIV = 2 and VENDOR_ID = 0x20. The second uses mode 3, CLK_DIV = 3 and VENDOR_ID = 0xC2. Together they cover both clock polarities, including the skipped first leading edge in mode 3, and an odd divider. They also show that the manufacturer match follows the parameter, because the default code is rejected by the second copy and accepted by the first. Each copy talks to a behavioural flash responder that logs every bit it receives, so the opcode, the dummy bytes and the single chip-select window can be seen at the pins.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;

  localparam int BYTE_W   = 8;
  localparam int N_XFERS  = 4;
  localparam int SS_W     = 5;
  localparam int SC_W     = 16;
  localparam int PS_W     = 4;
  localparam int PC_W     = 17;

  localparam logic [BYTE_W-1:0] OP_READ_ID = 8'h9F;
  localparam logic [BYTE_W-1:0] FILL_BYTE  = 8'hA5;
  localparam logic [BYTE_W-1:0] MEM_TYPE   = 8'h20;
  localparam logic [BYTE_W-1:0] CAP_SMALL  = 8'h11;
  localparam logic [BYTE_W-1:0] CAP_MID    = 8'h17;
  localparam logic [BYTE_W-1:0] CAP_LARGE  = 8'h18;

  typedef struct packed {
    logic [SS_W-1:0] sect_shift;
    logic [SC_W-1:0] sect_count;
    logic [PS_W-1:0] page_shift;
    logic [PC_W-1:0] page_count;
  } geom_t;

  typedef enum logic [2:0] {
    PS_PRE  = 3'd0,
    PS_LOAD = 3'd1,
    PS_WAIT = 3'd2,
    PS_EVAL = 3'd3,
    PS_IDLE = 3'd4
  } probe_st_t;

endpackage

// File: rtl/flash_spi_byte.sv
module flash_spi_byte
  import flash_id_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter bit CPOL    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o
);

  localparam int DIVW  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [DIVW-1:0] DIV_LAST  = DIVW'(CLK_DIV - 1);
  localparam logic [EW-1:0]   EDGE_LAST = EW'(EDGES - 1);

  logic              busy_q, busy_d;
  logic              ph_q, ph_d;
  logic [DIVW-1:0]   div_q, div_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              done_q, done_d;
  logic              tick;
  logic              sclk_lvl;

  assign sclk_lvl = ph_q ^ CPOL;
  assign tick     = busy_q && (div_q == DIV_LAST);

  // next-state logic: rising serial edge samples, falling edge shifts
  // (the very first falling edge of a byte in mode 3 only opens the frame)
  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    div_d  = div_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (go_i && !busy_q) begin
      busy_d = 1'b1;
      ph_d   = 1'b0;
      div_d  = '0;
      edge_d = '0;
      tx_d   = tx_i;
    end else if (busy_q) begin
      if (tick) begin
        div_d  = '0;
        ph_d   = ~ph_q;
        edge_d = edge_q + EW'(1);
        if (!sclk_lvl) begin
          rx_d = {rx_q[BYTE_W-2:0], miso_i};
        end else if (edge_q != '0) begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        end
        if (edge_q == EDGE_LAST) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        div_d = div_q + DIVW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      div_q  <= div_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = sclk_lvl;
  assign mosi_o = tx_q[BYTE_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/flash_id_decode.sv
module flash_id_decode
  import flash_id_pkg::*;
#(
  parameter logic [7:0] VENDOR_ID = 8'h20
) (
  input  logic [BYTE_W-1:0] mfr_i,
  input  logic [BYTE_W-1:0] type_i,
  input  logic [BYTE_W-1:0] cap_i,
  output logic              known_o,
  output geom_t             geom_o
);

  always_comb begin
    known_o = 1'b0;
    geom_o  = '0;
    if ((mfr_i == VENDOR_ID) && (type_i == MEM_TYPE)) begin
      case (cap_i)
        CAP_SMALL: begin
          known_o = 1'b1;
          geom_o  = '{sect_shift: 5'd15, sect_count: 16'd4,
                      page_shift: 4'd8,  page_count: 17'd512};
        end
        CAP_MID: begin
          known_o = 1'b1;
          geom_o  = '{sect_shift: 5'd16, sect_count: 16'd128,
                      page_shift: 4'd8,  page_count: 17'd32768};
        end
        CAP_LARGE: begin
          known_o = 1'b1;
          geom_o  = '{sect_shift: 5'd18, sect_count: 16'd64,
                      page_shift: 4'd8,  page_count: 17'd65536};
        end
        default: begin
          known_o = 1'b0;
          geom_o  = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_pkg::*;
#(
  parameter int         CLK_DIV   = 2,
  parameter bit         SPI_MODE3 = 1'b0,
  parameter logic [7:0] VENDOR_ID = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic            spi_sclk_o,
  output logic            spi_mosi_o,
  input  logic            spi_miso_i,
  output logic            spi_cs_n_o,
  output logic            done_o,
  output logic            dev_ok_o,
  output logic            dev_unknown_o,
  output logic [SS_W-1:0] sect_shift_o,
  output logic [SC_W-1:0] sect_count_o,
  output logic [PS_W-1:0] page_shift_o,
  output logic [PC_W-1:0] page_count_o
);

  localparam int IW = $clog2(N_XFERS);
  localparam logic [IW-1:0] IDX_LAST = IW'(N_XFERS - 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  probe_st_t         st_q, st_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              go, cap_en, res_en, clr;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              xfer_done;
  logic [BYTE_W-1:0] resp_q [N_XFERS-1];
  logic              known;
  geom_t             geom_dec;
  logic              done_q, ok_q, unk_q;
  geom_t             geom_q;

  assign tx_byte = (idx_q == '0) ? OP_READ_ID : FILL_BYTE;

  flash_spi_byte #(
    .CLK_DIV (CLK_DIV),
    .CPOL    (SPI_MODE3)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .go_i   (go),
    .tx_i   (tx_byte),
    .miso_i (spi_miso_i),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .done_o (xfer_done),
    .rx_o   (rx_byte)
  );

  flash_id_decode #(
    .VENDOR_ID (VENDOR_ID)
  ) u_decode (
    .mfr_i   (resp_q[0]),
    .type_i  (resp_q[1]),
    .cap_i   (resp_q[2]),
    .known_o (known),
    .geom_o  (geom_dec)
  );

  // sequencer next-state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    go     = 1'b0;
    cap_en = 1'b0;
    res_en = 1'b0;
    clr    = 1'b0;
    case (st_q)
      PS_PRE: begin
        idx_d = '0;
        st_d  = PS_LOAD;
      end
      PS_LOAD: begin
        go   = 1'b1;
        st_d = PS_WAIT;
      end
      PS_WAIT: begin
        if (xfer_done) begin
          cap_en = 1'b1;
          if (idx_q == IDX_LAST) begin
            st_d = PS_EVAL;
          end else begin
            idx_d = idx_q + IW'(1);
            st_d  = PS_LOAD;
          end
        end
      end
      PS_EVAL: begin
        res_en = 1'b1;
        st_d   = PS_IDLE;
      end
      PS_IDLE: begin
        if (start_i) begin
          clr  = 1'b1;
          st_d = PS_PRE;
        end
      end
      default: st_d = PS_PRE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= PS_PRE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // response capture: the byte clocked in under the opcode is discarded
  generate
    for (genvar g = 0; g < N_XFERS - 1; g++) begin : g_resp
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) begin
          resp_q[g] <= '0;
        end else if (cap_en && (idx_q == IW'(g + 1))) begin
          resp_q[g] <= rx_byte;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      unk_q  <= 1'b0;
      geom_q <= '0;
    end else if (clr) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      unk_q  <= 1'b0;
      geom_q <= '0;
    end else if (res_en) begin
      done_q <= 1'b1;
      ok_q   <= known;
      unk_q  <= !known;
      geom_q <= geom_dec;
    end
  end

  assign spi_cs_n_o    = !((st_q == PS_LOAD) || (st_q == PS_WAIT));
  assign done_o        = done_q;
  assign dev_ok_o      = ok_q;
  assign dev_unknown_o = unk_q;
  assign sect_shift_o  = geom_q.sect_shift;
  assign sect_count_o  = geom_q.sect_count;
  assign page_shift_o  = geom_q.page_shift;
  assign page_count_o  = geom_q.page_count;

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk
  import flash_id_pkg::*;
#(
  parameter bit MODE3 = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            spi_sclk_o,
  input logic            spi_cs_n_o,
  input logic            done_o,
  input logic            dev_ok_o,
  input logic            dev_unknown_o,
  input logic [SS_W-1:0] sect_shift_o,
  input logic [SC_W-1:0] sect_count_o,
  input logic [PS_W-1:0] page_shift_o,
  input logic [PC_W-1:0] page_count_o
);

  logic [39:0] bytes_by_sect;
  logic [39:0] bytes_by_page;

  assign bytes_by_sect = 40'(sect_count_o) << sect_shift_o;
  assign bytes_by_page = 40'(page_count_o) << page_shift_o;

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> (spi_sclk_o == MODE3)) else $error("sclk not idle"); // R11

  AST_CS_HIGH_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> spi_cs_n_o) else $error("cs low while done"); // R2

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (dev_ok_o ^ dev_unknown_o)) else $error("status not exclusive"); // R8

  AST_NO_STATUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !(dev_ok_o || dev_unknown_o)) else $error("status while busy"); // R9

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o) else $error("done dropped"); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !done_o) else $error("start did not clear"); // R9

  AST_GEOM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ok_o |-> ((sect_shift_o == '0) && (sect_count_o == '0) &&
                   (page_shift_o == '0) && (page_count_o == '0)))
    else $error("geometry not zero"); // R8

  AST_GEOM_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ok_o |-> ((bytes_by_sect == bytes_by_page) && (bytes_by_sect != '0)))
    else $error("geometry inconsistent"); // R5 R6 R7

endmodule

bind flash_id_probe flash_id_probe_chk #(.MODE3(SPI_MODE3)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .spi_sclk_o    (spi_sclk_o),
  .spi_cs_n_o    (spi_cs_n_o),
  .done_o        (done_o),
  .dev_ok_o      (dev_ok_o),
  .dev_unknown_o (dev_unknown_o),
  .sect_shift_o  (sect_shift_o),
  .sect_count_o  (sect_count_o),
  .page_shift_o  (page_shift_o),
  .page_count_o  (page_count_o)
);

// File: tb/flash_id_probe_tb.sv
`timescale 1ns/1ps

module spi_id_responder (
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic [23:0] id_i,
  output logic        miso,
  output logic [31:0] mosi_log,
  output int          nrise,
  output int          ncs
);
  int          nshift;
  logic [31:0] shr;

  initial begin
    ncs = 0; nrise = 0; nshift = 0; miso = 1'b0; mosi_log = '0; shr = '0;
  end

  always @(negedge cs_n) begin
    shr      = {8'hFF, id_i};
    nrise    = 0;
    nshift   = 0;
    ncs      = ncs + 1;
    mosi_log = '0;
    miso     = shr[31];
  end

  always @(posedge sclk) begin
    if (cs_n === 1'b0) begin
      mosi_log = {mosi_log[30:0], mosi};
      nrise    = nrise + 1;
    end
  end

  always @(negedge sclk) begin
    if ((cs_n === 1'b0) && (nshift < nrise)) begin
      shr    = shr << 1;
      nshift = nshift + 1;
      miso   = shr[31];
    end
  end
endmodule

module flash_id_probe_tb;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic        st0, st3;
  logic [23:0] id0, id3;

  logic        sclk0, mosi0, miso0, cs0, done0, ok0, unk0;
  logic [4:0]  ss0; logic [15:0] sc0; logic [3:0] ps0; logic [16:0] pc0;
  logic [31:0] log0; int nr0, ncs0;

  logic        sclk3, mosi3, miso3, cs3, done3, ok3, unk3;
  logic [4:0]  ss3; logic [15:0] sc3; logic [3:0] ps3; logic [16:0] pc3;
  logic [31:0] log3; int nr3, ncs3;

  flash_id_probe u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(st0),
    .spi_sclk_o(sclk0), .spi_mosi_o(mosi0), .spi_miso_i(miso0), .spi_cs_n_o(cs0),
    .done_o(done0), .dev_ok_o(ok0), .dev_unknown_o(unk0),
    .sect_shift_o(ss0), .sect_count_o(sc0), .page_shift_o(ps0), .page_count_o(pc0)
  );

  flash_id_probe #(.CLK_DIV(3), .SPI_MODE3(1'b1), .VENDOR_ID(8'hC2)) u_dut_m3 (
    .clk(clk), .rst_n(rst_n), .start_i(st3),
    .spi_sclk_o(sclk3), .spi_mosi_o(mosi3), .spi_miso_i(miso3), .spi_cs_n_o(cs3),
    .done_o(done3), .dev_ok_o(ok3), .dev_unknown_o(unk3),
    .sect_shift_o(ss3), .sect_count_o(sc3), .page_shift_o(ps3), .page_count_o(pc3)
  );

  spi_id_responder u_flash0 (.sclk(sclk0), .cs_n(cs0), .mosi(mosi0), .id_i(id0),
    .miso(miso0), .mosi_log(log0), .nrise(nr0), .ncs(ncs0));
  spi_id_responder u_flash3 (.sclk(sclk3), .cs_n(cs3), .mosi(mosi3), .id_i(id3),
    .miso(miso3), .mosi_log(log3), .nrise(nr3), .ncs(ncs3));

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [42:0] exp_geom(input logic [7:0] vend, input logic [23:0] id);
    if (id[23:16] != vend || id[15:8] != 8'h20) return '0;
    case (id[7:0])
      8'h11:   return {1'b1, 5'd15, 16'd4,   4'd8, 17'd512};
      8'h17:   return {1'b1, 5'd16, 16'd128, 4'd8, 17'd32768};
      8'h18:   return {1'b1, 5'd18, 16'd64,  4'd8, 17'd65536};
      default: return '0;
    endcase
  endfunction

  function automatic string req_tag(input logic [7:0] vend, input logic [23:0] id);
    if (id[23:16] != vend || id[15:8] != 8'h20) return "R4";
    case (id[7:0])
      8'h11:   return "R5";
      8'h17:   return "R6";
      8'h18:   return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [42:0] got(input int d);
    if (d == 0) return {ok0, ss0, sc0, ps0, pc0};
    return {ok3, ss3, sc3, ps3, pc3};
  endfunction

  function automatic logic get_done(input int d); return (d == 0) ? done0 : done3; endfunction
  function automatic logic get_cs(input int d);   return (d == 0) ? cs0 : cs3;     endfunction
  function automatic logic get_sclk(input int d); return (d == 0) ? sclk0 : sclk3; endfunction
  function automatic logic get_unk(input int d);  return (d == 0) ? unk0 : unk3;   endfunction
  function automatic int   get_ncs(input int d);  return (d == 0) ? ncs0 : ncs3;   endfunction
  function automatic logic [7:0] vend_of(input int d); return (d == 0) ? 8'h20 : 8'hC2; endfunction

  task automatic set_id(input int d, input logic [23:0] id);
    if (d == 0) id0 = id; else id3 = id;
  endtask

  task automatic pulse_start(input int d);
    @(negedge clk);
    if (d == 0) st0 = 1'b1; else st3 = 1'b1;
    @(negedge clk);
    st0 = 1'b0; st3 = 1'b0;
  endtask

  task automatic wait_done(input int d);
    int n = 0;
    while (get_done(d) !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(get_done(d) === 1'b1, "R2", "probe completion", 64'(get_done(d)), 64'd1);
  endtask

  task automatic verify(input int d, input logic [23:0] id, input int ncs_before);
    logic [42:0] e;
    logic [31:0] lg;
    int nr;
    e  = exp_geom(vend_of(d), id);
    lg = (d == 0) ? log0 : log3;
    nr = (d == 0) ? nr0 : nr3;
    check(got(d) === e, req_tag(vend_of(d), id), "geometry/valid", 64'(got(d)), 64'(e));
    check(get_unk(d) === ~e[42], "R8", "unknown flag", 64'(get_unk(d)), 64'(~e[42]));
    check(lg === 32'h9FA5A5A5, "R2", "bits sent under chip select", 64'(lg), 64'h9FA5A5A5);
    check(nr == 32, "R2", "serial clocks per probe", 64'(nr), 64'd32);
    check(get_ncs(d) - ncs_before == 1, "R2", "chip select assertions",
          64'(get_ncs(d) - ncs_before), 64'd1);
    check(get_cs(d) === 1'b1, "R2", "chip select after probe", 64'(get_cs(d)), 64'd1);
    check(get_sclk(d) === ((d == 0) ? 1'b0 : 1'b1), "R11", "sclk idle after probe",
          64'(get_sclk(d)), 64'((d == 0) ? 0 : 1));
  endtask

  task automatic probe(input int d, input logic [23:0] id);
    int nb;
    set_id(d, id);
    nb = get_ncs(d);
    pulse_start(d);
    check(get_done(d) === 1'b0, "R9", "done cleared by start", 64'(get_done(d)), 64'd0);
    wait_done(d);
    verify(d, id, nb);
  endtask

  task automatic probe_timed(input int d, input logic [23:0] id, input int div);
    int nb, n, cnt;
    logic lvl;
    set_id(d, id);
    nb  = get_ncs(d);
    lvl = (d == 0) ? 1'b0 : 1'b1;
    pulse_start(d);
    n = 0;
    while (get_sclk(d) === lvl && n < 1000) begin @(negedge clk); n++; end
    cnt = 0;
    while (get_sclk(d) !== lvl && cnt < 1000) begin @(negedge clk); cnt++; end
    check(cnt == div, "R12", "sclk half period", 64'(cnt), 64'(div));
    wait_done(d);
    verify(d, id, nb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] id;
    int nb;
    logic [42:0] held;
    void'($urandom(32'd7321));
    rst_n = 1'b0; st0 = 1'b0; st3 = 1'b0;
    id0 = 24'h202017; id3 = 24'hC22018;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(cs0 === 1'b1 && cs3 === 1'b1, "R1", "cs during reset", 64'({cs0, cs3}), 64'h3);
    check(done0 === 1'b0 && done3 === 1'b0, "R1", "done during reset", 64'({done0, done3}), 64'h0);
    check({ok0, unk0, ok3, unk3} === 4'b0, "R1", "status during reset",
          64'({ok0, unk0, ok3, unk3}), 64'h0);
    check(sclk0 === 1'b0, "R11", "mode 0 sclk idle", 64'(sclk0), 64'd0);
    check(sclk3 === 1'b1, "R11", "mode 3 sclk idle", 64'(sclk3), 64'd1);
    rst_n = 1'b1;
    // R1 automatic probe on both copies
    wait_done(0);
    verify(0, 24'h202017, 0);
    wait_done(1);
    verify(1, 24'hC22018, 0);

    // directed capacity and acceptance cases
    probe_timed(0, 24'h202011, 2);   // R5, R12
    probe(0, 24'h202018);            // R7
    probe(0, 24'h202017);            // R6
    probe(0, 24'hC22017);            // R4 manufacturer mismatch
    probe(0, 24'h202118);            // R4 memory type mismatch
    probe(0, 24'h202016);            // R8 unknown capacity
    probe(0, 24'h2020FF);            // R8
    probe_timed(1, 24'hC22011, 3);   // R12 mode 3, R3
    probe(1, 24'h202018);            // R4 default vendor rejected here
    probe(1, 24'hC22017);            // R6

    // R9 hold: result stable while idle without start
    held = got(0);
    repeat (60) @(negedge clk);
    check(done0 === 1'b1, "R9", "done held", 64'(done0), 64'd1);
    check(got(0) === held, "R9", "result held", 64'(got(0)), 64'(held));

    // R10 start during a running probe
    set_id(0, 24'h202018);
    nb = ncs0;
    pulse_start(0);
    repeat (30) @(negedge clk);
    pulse_start(0);
    wait_done(0);
    verify(0, 24'h202018, nb);
    repeat (80) @(negedge clk);
    check(ncs0 - nb == 1, "R10", "no second probe", 64'(ncs0 - nb), 64'd1);
    check(done0 === 1'b1 && cs0 === 1'b1, "R10", "idle after ignored start",
          64'({done0, cs0}), 64'h3);

    // random identification patterns
    for (int i = 0; i < 24; i++) begin
      int d;
      d = (i % 4 == 3) ? 1 : 0;
      case ($urandom % 4)
        0:       id[23:16] = 8'h20;
        1:       id[23:16] = 8'hC2;
        2:       id[23:16] = vend_of(d);
        default: id[23:16] = 8'($urandom);
      endcase
      id[15:8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'h20;
      case ($urandom % 5)
        0:       id[7:0] = 8'h11;
        1:       id[7:0] = 8'h17;
        2:       id[7:0] = 8'h18;
        3:       id[7:0] = 8'h10 + 8'($urandom % 16);
        default: id[7:0] = 8'($urandom);
      endcase
      probe(d, id);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule